// File: doc/BRIEF.md
# I2C Controller Register and Interrupt Unit

This block is the memory-mapped register file and interrupt logic that sits in front of an I2C master's bus engine. Software pushes command words (a data byte plus start and stop flags) into a command FIFO. The bus engine drains that FIFO. Bytes the engine receives go into a receive FIFO, and software pops them. Software also programs the control bits, the interrupt enables and three timing counts. The timing counts are presented to the engine as plain outputs.

Two interrupt sources follow FIFO levels against programmable thresholds: transmit ready and receive ready. Three are error events that latch: NACK detected, arbitration lost and receive overflow. The latched bits are cleared by writing one to them. A single interrupt line is high whenever a status bit and its enable bit are both set. The bus engine itself is outside the block. It appears only as a pop strobe, a receive push, event pulses and a busy level.

The bus interface is a single-cycle strobe interface. Read data is combinational from the address. A read of the receive data register pops the FIFO at the clock edge that ends the access.

Top module: `i2c_regif`

## Requirements
- R1: After synchronous reset, control, enable, timing and latched status registers are zero, both FIFOs are empty, `irq` is low, and the status register reads 1 (transmit ready only, since level 0 is within threshold 0).
- R2: A write to byte offset 0x00 pushes `bus_wdata[9:0]` (bit 9 start, bit 8 stop, bits 7:0 data) into the command FIFO. `cmd_valid` is high while the FIFO holds an entry, `cmd_word` shows the oldest entry, and `cmd_pop` removes it, in first-in first-out order.
- R3: A write to offset 0x00 while the command FIFO holds DEPTH entries is ignored. The level and contents are unchanged.
- R4: A read at offset 0x04 returns the oldest received byte in bits 7:0 and removes it. A read of an empty receive FIFO returns 0 and changes nothing.
- R5: Offset 0x18 reads the command FIFO entry count and offset 0x1C reads the receive FIFO entry count, each between 0 and DEPTH.
- R6: Offset 0x08 is read/write control. Bit 0 drives `core_en`, bit 1 drives `fast_mode`, bits 3:2 are the command threshold and bits 5:4 are the receive threshold.
- R7: Status bit 0 (transmit ready) is high while the command level is at most the command threshold. Status bit 1 (receive ready) is high while the receive level is at least the receive threshold plus one. Both bits follow the levels and are not latched.
- R8: Status bit 2 (NACK) latches on `nack_evt` and status bit 3 (arbitration lost) latches on `arb_evt`. Writing 1 to a bit at offset 0x10 clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set.
- R9: A `rx_push` while the receive FIFO is full drops the byte, leaves the FIFO unchanged, and latches status bit 4 (receive overflow). Bit 4 is cleared by writing one to it.
- R10: Offset 0x0C holds the interrupt enables in the same bit layout as the status register. `irq` is high exactly when some status bit and its enable bit are both 1.
- R11: Offset 0x14 bit 0 reads `core_busy`, where 0 means idle.
- R12: Offsets 0x20 (SCL low), 0x24 (SCL high) and 0x28 (SDA hold) are CNT_W-bit read/write counts that drive `scl_low_cnt`, `scl_high_cnt` and `sda_hold_cnt`.
- R13: Reads of unmapped or unaligned offsets return 0. Writes to read-only offsets (0x04, 0x10 aside from clearing, 0x14, 0x18, 0x1C) change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| cmd_valid | output | 1 | Command FIFO not empty |
| cmd_word | output | 10 | Oldest command {start, stop, data} |
| cmd_pop | input | 1 | Engine consumes the oldest command |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| nack_evt | input | 1 | NACK detected pulse |
| arb_evt | input | 1 | Arbitration lost pulse |
| core_busy | input | 1 | Engine busy level |
| core_en | output | 1 | Control enable bit |
| fast_mode | output | 1 | Control fast speed bit |
| scl_low_cnt | output | CNT_W | SCL low count |
| scl_high_cnt | output | CNT_W | SCL high count |
| sda_hold_cnt | output | CNT_W | SDA hold count |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions check these properties on every cycle:
- FIFO levels stay within their bounds.
- A full command FIFO does not grow when written.
- An overflowing receive push leaves the level untouched and sets the overflow bit.
- A latched NACK survives any cycle without a matching clear.
- The interrupt stays low while all enables are zero.
- `cmd_valid` tracks the command level.

Only the bench scenarios can show the following:
- FIFO data ordering.
- The exact threshold comparisons for the ready bits.
- Register readback.
- The same-cycle event-versus-clear priority.
- Agreement between the full status map and a reference model under mixed random traffic.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;

    localparam int ADDR_W  = 6;
    localparam int DATA_W  = 32;
    localparam int CMD_W   = 10;
    localparam int BYTE_W  = 8;
    localparam int THR_W   = 2;
    localparam int NUM_IRQ = 5;
    localparam int NUM_LAT = 3;
    localparam int NUM_TIM = 3;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_RXD   = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_IST   = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CLVL  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_RLVL  = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_SLOW  = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_SHIGH = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_HOLD  = 6'h28;

    typedef struct packed {
        logic [THR_W-1:0] rx_thr;
        logic [THR_W-1:0] cmd_thr;
        logic             fast;
        logic             en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic rx_ovf;
        logic arb_lost;
        logic nack;
        logic rx_rdy;
        logic tx_rdy;
    } irq_vec_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_RXD,
        SEL_CTRL,
        SEL_IEN,
        SEL_IST,
        SEL_STAT,
        SEL_CLVL,
        SEL_RLVL,
        SEL_SLOW,
        SEL_SHIGH,
        SEL_HOLD
    } sel_e;

    function automatic sel_e decode_addr(input logic [ADDR_W-1:0] a);
        sel_e s;
        case (a)
            OFS_CMD:   s = SEL_CMD;
            OFS_RXD:   s = SEL_RXD;
            OFS_CTRL:  s = SEL_CTRL;
            OFS_IEN:   s = SEL_IEN;
            OFS_IST:   s = SEL_IST;
            OFS_STAT:  s = SEL_STAT;
            OFS_CLVL:  s = SEL_CLVL;
            OFS_RLVL:  s = SEL_RLVL;
            OFS_SLOW:  s = SEL_SLOW;
            OFS_SHIGH: s = SEL_SHIGH;
            OFS_HOLD:  s = SEL_HOLD;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/i2c_regif_fifo.sv
module i2c_regif_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic             do_push;
    logic             do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= ptr_next(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/i2c_regif_cfg.sv
module i2c_regif_cfg
    import i2c_regif_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  sel_e              sel,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output irq_vec_t          ien,
    output logic [CNT_W-1:0]  tim [NUM_TIM]
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
            ien  <= '0;
        end else if (wr) begin
            if (sel == SEL_CTRL) begin
                ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            end
            if (sel == SEL_IEN) begin
                ien <= irq_vec_t'(wdata[NUM_IRQ-1:0]);
            end
        end
    end

    for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
        localparam sel_e MY_SEL = (g == 0) ? SEL_SLOW : (g == 1) ? SEL_SHIGH : SEL_HOLD;
        always_ff @(posedge clk) begin
            if (rst) begin
                tim[g] <= '0;
            end else if (wr && sel == MY_SEL) begin
                tim[g] <= wdata[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/i2c_regif_irq.sv
module i2c_regif_irq
    import i2c_regif_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LVL_W-1:0]   cmd_lvl,
    input  logic [LVL_W-1:0]   rx_lvl,
    input  logic [THR_W-1:0]   cmd_thr,
    input  logic [THR_W-1:0]   rx_thr,
    input  logic               nack_evt,
    input  logic               arb_evt,
    input  logic               ovf_evt,
    input  logic               clr_en,
    input  logic [NUM_IRQ-1:0] clr_bits,
    input  irq_vec_t           ien,
    output irq_vec_t           status,
    output logic               irq
);

    logic [NUM_LAT-1:0] evt;
    logic [NUM_LAT-1:0] clr;
    logic [NUM_LAT-1:0] lat;
    logic               tx_rdy;
    logic               rx_rdy;

    assign evt = {ovf_evt, arb_evt, nack_evt};
    assign clr = clr_en ? clr_bits[NUM_IRQ-1:NUM_IRQ-NUM_LAT] : '0;

    for (genvar g = 0; g < NUM_LAT; g++) begin : g_lat
        always_ff @(posedge clk) begin
            if (rst) begin
                lat[g] <= 1'b0;
            end else if (evt[g]) begin
                lat[g] <= 1'b1;
            end else if (clr[g]) begin
                lat[g] <= 1'b0;
            end
        end
    end

    assign tx_rdy = (cmd_lvl <= LVL_W'(cmd_thr));
    assign rx_rdy = (rx_lvl > LVL_W'(rx_thr));

    assign status = irq_vec_t'({lat, rx_rdy, tx_rdy});
    assign irq    = |(status & ien);

    logic unused_clr;
    assign unused_clr = ^clr_bits[NUM_IRQ-NUM_LAT-1:0];

endmodule

// File: rtl/i2c_regif.sv
module i2c_regif
    import i2c_regif_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cmd_valid,
    output logic [CMD_W-1:0]  cmd_word,
    input  logic              cmd_pop,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              nack_evt,
    input  logic              arb_evt,
    input  logic              core_busy,
    output logic              core_en,
    output logic              fast_mode,
    output logic [CNT_W-1:0]  scl_low_cnt,
    output logic [CNT_W-1:0]  scl_high_cnt,
    output logic [CNT_W-1:0]  sda_hold_cnt,
    output logic              irq
);

    localparam int LVL_W = $clog2(DEPTH + 1);

    sel_e              sel;
    logic              cmd_push;
    logic              rx_pop;
    logic              ist_wr;
    logic [LVL_W-1:0]  cmd_lvl;
    logic [LVL_W-1:0]  rx_lvl;
    logic              cmd_full;
    logic              cmd_empty;
    logic              rx_full;
    logic              rx_empty;
    logic [BYTE_W-1:0] rx_head;
    ctrl_t             ctrl;
    irq_vec_t          ien_q;
    irq_vec_t          stat;
    logic [CNT_W-1:0]  tim [NUM_TIM];

    assign sel      = decode_addr(bus_addr);
    assign cmd_push = bus_wr && (sel == SEL_CMD);
    assign rx_pop   = bus_rd && (sel == SEL_RXD);
    assign ist_wr   = bus_wr && (sel == SEL_IST);

    i2c_regif_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_cmd_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (cmd_push),
        .push_data (bus_wdata[CMD_W-1:0]),
        .pop       (cmd_pop),
        .head      (cmd_word),
        .level     (cmd_lvl),
        .full      (cmd_full),
        .empty     (cmd_empty)
    );

    i2c_regif_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rx_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_push),
        .push_data (rx_byte),
        .pop       (rx_pop),
        .head      (rx_head),
        .level     (rx_lvl),
        .full      (rx_full),
        .empty     (rx_empty)
    );

    i2c_regif_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .ctrl  (ctrl),
        .ien   (ien_q),
        .tim   (tim)
    );

    i2c_regif_irq #(.LVL_W(LVL_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .cmd_lvl  (cmd_lvl),
        .rx_lvl   (rx_lvl),
        .cmd_thr  (ctrl.cmd_thr),
        .rx_thr   (ctrl.rx_thr),
        .nack_evt (nack_evt),
        .arb_evt  (arb_evt),
        .ovf_evt  (rx_push && rx_full),
        .clr_en   (ist_wr),
        .clr_bits (bus_wdata[NUM_IRQ-1:0]),
        .ien      (ien_q),
        .status   (stat),
        .irq      (irq)
    );

    assign cmd_valid    = !cmd_empty;
    assign core_en      = ctrl.en;
    assign fast_mode    = ctrl.fast;
    assign scl_low_cnt  = tim[0];
    assign scl_high_cnt = tim[1];
    assign sda_hold_cnt = tim[2];

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_RXD:   bus_rdata = rx_empty ? '0 : DATA_W'(rx_head);
            SEL_CTRL:  bus_rdata = DATA_W'(ctrl);
            SEL_IEN:   bus_rdata = DATA_W'(ien_q);
            SEL_IST:   bus_rdata = DATA_W'(stat);
            SEL_STAT:  bus_rdata = DATA_W'(core_busy);
            SEL_CLVL:  bus_rdata = DATA_W'(cmd_lvl);
            SEL_RLVL:  bus_rdata = DATA_W'(rx_lvl);
            SEL_SLOW:  bus_rdata = DATA_W'(tim[0]);
            SEL_SHIGH: bus_rdata = DATA_W'(tim[1]);
            SEL_HOLD:  bus_rdata = DATA_W'(tim[2]);
            default:   bus_rdata = '0;
        endcase
    end

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata[DATA_W-1:CMD_W];

endmodule

module i2c_regif_chk
    import i2c_regif_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              cmd_pop,
    input logic              cmd_valid,
    input logic              rx_push,
    input logic              nack_evt,
    input logic [LVL_W-1:0]  cmd_lvl,
    input logic [LVL_W-1:0]  rx_lvl,
    input irq_vec_t          stat,
    input irq_vec_t          ien_q,
    input logic              irq
);

    logic wr_cmd;
    logic rd_rxd;
    logic clr_nack;
    logic rx_is_full;
    logic cmd_is_full;

    assign wr_cmd      = bus_wr && (bus_addr == OFS_CMD);
    assign rd_rxd      = bus_rd && (bus_addr == OFS_RXD);
    assign clr_nack    = bus_wr && (bus_addr == OFS_IST) && bus_wdata[2];
    assign rx_is_full  = (rx_lvl == LVL_W'(DEPTH));
    assign cmd_is_full = (cmd_lvl == LVL_W'(DEPTH));

    AST_LVL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cmd_lvl <= LVL_W'(DEPTH)) && (rx_lvl <= LVL_W'(DEPTH))); // R5

    AST_CMD_FULL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && cmd_is_full && !cmd_pop) |=> (cmd_lvl == $past(cmd_lvl))); // R3

    AST_RXOF_LATCH: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_is_full) |=> stat.rx_ovf); // R9

    AST_RX_DROP: assert property (@(posedge clk) disable iff (rst)
        (rx_push && rx_is_full && !rd_rxd) |=> (rx_lvl == $past(rx_lvl))); // R9

    AST_NACK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stat.nack && !clr_nack) |=> stat.nack); // R8

    AST_NACK_SET: assert property (@(posedge clk) disable iff (rst)
        nack_evt |=> stat.nack); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (ien_q == '0) |-> !irq); // R10

    AST_CMD_VALID: assert property (@(posedge clk) disable iff (rst)
        cmd_valid == (cmd_lvl != '0)); // R2

endmodule

bind i2c_regif i2c_regif_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cmd_pop   (cmd_pop),
    .cmd_valid (cmd_valid),
    .rx_push   (rx_push),
    .nack_evt  (nack_evt),
    .cmd_lvl   (cmd_lvl),
    .rx_lvl    (rx_lvl),
    .stat      (stat),
    .ien_q     (ien_q),
    .irq       (irq)
);

// File: tb/i2c_regif_tb.sv
module i2c_regif_tb;
    import i2c_regif_pkg::*;

    localparam int DEPTH = 4;
    localparam int CNT_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              cmd_valid;
    logic [CMD_W-1:0]  cmd_word;
    logic              cmd_pop = 1'b0;
    logic              rx_push = 1'b0;
    logic [BYTE_W-1:0] rx_byte = '0;
    logic              nack_evt = 1'b0;
    logic              arb_evt = 1'b0;
    logic              core_busy = 1'b0;
    logic              core_en;
    logic              fast_mode;
    logic [CNT_W-1:0]  scl_low_cnt;
    logic [CNT_W-1:0]  scl_high_cnt;
    logic [CNT_W-1:0]  sda_hold_cnt;
    logic              irq;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    i2c_regif #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .cmd_valid    (cmd_valid),
        .cmd_word     (cmd_word),
        .cmd_pop      (cmd_pop),
        .rx_push      (rx_push),
        .rx_byte      (rx_byte),
        .nack_evt     (nack_evt),
        .arb_evt      (arb_evt),
        .core_busy    (core_busy),
        .core_en      (core_en),
        .fast_mode    (fast_mode),
        .scl_low_cnt  (scl_low_cnt),
        .scl_high_cnt (scl_high_cnt),
        .sda_hold_cnt (sda_hold_cnt),
        .irq          (irq)
    );

    // reference model state
    logic [CMD_W-1:0]  m_cmd [$];
    logic [BYTE_W-1:0] m_rx [$];
    logic [2:0]        m_lat = '0;
    logic [5:0]        m_ctrl = '0;
    logic [4:0]        m_ien = '0;

    function automatic logic [4:0] exp_status();
        logic txr, rxr;
        txr = (m_cmd.size() <= int'(m_ctrl[3:2]));
        rxr = (m_rx.size() >= int'(m_ctrl[5:4]) + 1);
        return {m_lat, rxr, txr};
    endfunction

    function automatic logic exp_irq();
        return |(exp_status() & m_ien);
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bwr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_in(input logic [BYTE_W-1:0] b);
        @(negedge clk);
        rx_push = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic eng_pop(output logic [CMD_W-1:0] w);
        @(negedge clk);
        w = cmd_word; cmd_pop = 1'b1;
        @(negedge clk);
        cmd_pop = 1'b0;
    endtask

    task automatic pulse_evt(input logic n, input logic a);
        @(negedge clk);
        nack_evt = n; arb_evt = a;
        @(negedge clk);
        nack_evt = 1'b0; arb_evt = 1'b0;
    endtask

    task automatic check_model(input string tag);
        logic [DATA_W-1:0] d;
        brd(OFS_IST, d);
        check({tag, " R7 R8 R9 status"}, d, 32'(exp_status()));
        brd(OFS_CLVL, d);
        check({tag, " R5 cmd level"}, d, 32'(m_cmd.size()));
        brd(OFS_RLVL, d);
        check({tag, " R5 rx level"}, d, 32'(m_rx.size()));
        check({tag, " R10 irq"}, 32'(irq), 32'(exp_irq()));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] d;
        logic [CMD_W-1:0]  w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        brd(OFS_CTRL, d);  check("R1 ctrl", d, 0);
        brd(OFS_IST, d);   check("R1 status", d, 32'h1);
        brd(OFS_SLOW, d);  check("R1 scl low", d, 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 cmd_valid", 32'(cmd_valid), 0);

        // R6 control
        bwr(OFS_CTRL, 32'hFFFF_FF03); m_ctrl = 6'h03;
        brd(OFS_CTRL, d); check("R6 ctrl readback", d, 32'h03);
        check("R6 core_en", 32'(core_en), 1);
        check("R6 fast_mode", 32'(fast_mode), 1);
        bwr(OFS_CTRL, 32'h00); m_ctrl = 6'h00;
        check("R6 core_en off", 32'(core_en), 0);

        // R12 timing counts
        bwr(OFS_SLOW, 32'h1234);
        bwr(OFS_SHIGH, 32'h00AB);
        bwr(OFS_HOLD, 32'h001E);
        brd(OFS_SHIGH, d); check("R12 high readback", d, 32'h00AB);
        check("R12 scl_low_cnt", 32'(scl_low_cnt), 32'h1234);
        check("R12 sda_hold_cnt", 32'(sda_hold_cnt), 32'h001E);

        // R2 R3 command FIFO fill and order
        for (int i = 0; i < DEPTH; i++) begin
            bwr(OFS_CMD, 32'(10'h200 + i));
            m_cmd.push_back(10'(10'h200 + i));
        end
        check("R2 cmd_valid", 32'(cmd_valid), 1);
        bwr(OFS_CMD, 32'h3FF);
        brd(OFS_CLVL, d); check("R3 full write ignored level", d, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            eng_pop(w);
            check("R2 R3 cmd order", 32'(w), 32'(m_cmd.pop_front()));
        end
        check("R2 cmd empty", 32'(cmd_valid), 0);

        // R7 transmit ready threshold
        bwr(OFS_CTRL, 32'h04); m_ctrl = 6'h04;
        bwr(OFS_CMD, 32'h011); m_cmd.push_back(10'h011);
        brd(OFS_IST, d); check("R7 txrdy at thr", 32'(d[0]), 1);
        bwr(OFS_CMD, 32'h022); m_cmd.push_back(10'h022);
        brd(OFS_IST, d); check("R7 txrdy above thr", 32'(d[0]), 0);
        repeat (2) begin eng_pop(w); void'(m_cmd.pop_front()); end

        // R4 R5 R7 receive path
        rx_in(8'hA1); rx_in(8'hB2); rx_in(8'hC3);
        m_rx.push_back(8'hA1); m_rx.push_back(8'hB2); m_rx.push_back(8'hC3);
        brd(OFS_RLVL, d); check("R5 rx level", d, 3);
        bwr(OFS_CTRL, 32'h20); m_ctrl = 6'h20;
        brd(OFS_IST, d); check("R7 rxrdy level=thr+1", 32'(d[1]), 1);
        bwr(OFS_CTRL, 32'h30); m_ctrl = 6'h30;
        brd(OFS_IST, d); check("R7 rxrdy below", 32'(d[1]), 0);
        for (int i = 0; i < 3; i++) begin
            brd(OFS_RXD, d);
            check("R4 rx order", d, 32'(m_rx.pop_front()));
        end
        brd(OFS_RXD, d); check("R4 empty read", d, 0);
        brd(OFS_RLVL, d); check("R4 empty level", d, 0);

        // R9 overflow
        for (int i = 0; i < DEPTH + 1; i++) rx_in(8'(8'h10 + i));
        for (int i = 0; i < DEPTH; i++) m_rx.push_back(8'(8'h10 + i));
        m_lat[2] = 1'b1;
        brd(OFS_IST, d); check("R9 rxof set", 32'(d[4]), 1);
        brd(OFS_RLVL, d); check("R9 level kept", d, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            brd(OFS_RXD, d);
            check("R9 dropped byte absent", d, 32'(m_rx.pop_front()));
        end
        bwr(OFS_IST, 32'h10); m_lat[2] = 1'b0;
        brd(OFS_IST, d); check("R9 rxof cleared", 32'(d[4]), 0);

        // R8 latch and clear
        pulse_evt(1'b1, 1'b1); m_lat[1:0] = 2'b11;
        brd(OFS_IST, d); check("R8 nack arb set", 32'(d[3:2]), 3);
        bwr(OFS_IST, 32'h00);
        brd(OFS_IST, d); check("R8 write0 keeps", 32'(d[3:2]), 3);
        bwr(OFS_IST, 32'h04); m_lat[0] = 1'b0;
        brd(OFS_IST, d); check("R8 clear nack only", 32'(d[3:2]), 2);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = OFS_IST; bus_wdata = 32'h08; arb_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; arb_evt = 1'b0;
        brd(OFS_IST, d); check("R8 event beats clear", 32'(d[3]), 1);

        // R10 interrupt combine
        check("R10 no enables", 32'(irq), 0);
        bwr(OFS_IEN, 32'h08); m_ien = 5'h08;
        brd(OFS_IEN, d); check("R10 ien readback", d, 32'h08);
        check("R10 irq arb", 32'(irq), 1);
        bwr(OFS_IST, 32'h1F); m_lat = '0;
        check("R10 irq cleared", 32'(irq), 0);
        bwr(OFS_IEN, 32'h01); m_ien = 5'h01;
        check("R10 irq txrdy", 32'(irq), 1);
        bwr(OFS_IEN, 32'h00); m_ien = 5'h00;

        // R11 core status
        core_busy = 1'b1;
        brd(OFS_STAT, d); check("R11 busy", d, 1);
        core_busy = 1'b0;
        brd(OFS_STAT, d); check("R11 idle", d, 0);

        // R13 unmapped and read-only
        brd(6'h2C, d); check("R13 unmapped", d, 0);
        brd(6'h09, d); check("R13 unaligned", d, 0);
        bwr(OFS_CLVL, 32'h3); bwr(OFS_STAT, 32'hF); bwr(OFS_RXD, 32'h55);
        brd(OFS_CLVL, d); check("R13 ro cmd level", d, 0);
        brd(OFS_RLVL, d); check("R13 ro rx level", d, 0);
        brd(OFS_CTRL, d); check("R13 ctrl untouched", d, 32'(m_ctrl));

        // random traffic against the model
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 6));
            case (op)
                0: begin
                    logic [CMD_W-1:0] v;
                    v = CMD_W'($urandom());
                    bwr(OFS_CMD, 32'(v));
                    if (m_cmd.size() < DEPTH) m_cmd.push_back(v);
                end
                1: begin
                    if (m_cmd.size() > 0) begin
                        eng_pop(w);
                        check("R2 random cmd", 32'(w), 32'(m_cmd.pop_front()));
                    end
                end
                2: begin
                    logic [BYTE_W-1:0] b;
                    b = BYTE_W'($urandom());
                    rx_in(b);
                    if (m_rx.size() < DEPTH) m_rx.push_back(b);
                    else m_lat[2] = 1'b1;
                end
                3: begin
                    logic [BYTE_W-1:0] e;
                    e = (m_rx.size() > 0) ? m_rx.pop_front() : '0;
                    brd(OFS_RXD, d);
                    check("R4 random rx", d, 32'(e));
                end
                4: begin
                    m_ctrl = 6'($urandom());
                    bwr(OFS_CTRL, 32'(m_ctrl));
                end
                5: begin
                    m_ien = 5'($urandom());
                    bwr(OFS_IEN, 32'(m_ien));
                end
                default: begin
                    if ($urandom_range(0, 1) == 0) begin
                        logic n, a;
                        n = 1'($urandom()); a = 1'($urandom());
                        pulse_evt(n, a);
                        if (n) m_lat[0] = 1'b1;
                        if (a) m_lat[1] = 1'b1;
                    end else begin
                        logic [4:0] mk;
                        mk = 5'($urandom());
                        bwr(OFS_IST, 32'(mk));
                        m_lat = m_lat & ~mk[4:2];
                    end
                end
            endcase
            check_model("rand");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule